// File: doc/BRIEF.md
# Configurable SPI Byte Master

This block moves one byte at a time over a four-wire serial link as the clocking side. Software gives it a byte and a write strobe. The block then drives the serial clock for eight full periods. It shifts the byte out on the data output, most significant bit first, and at the same time assembles the byte coming back on the data input. When the exchange ends, it raises a completion flag in an 8-bit status word and presents the received byte. The idle level and the sampling edge of the serial clock can be set, so all four polarity/phase combinations are available. The clock rate comes from a two-bit rate code and a double-speed bit. Everything runs in the system clock domain: a divided enable marks each serial half-period.

Two protection paths are built in. If the data register is written while a byte is still moving, a collision flag is raised and the running exchange carries on untouched. If the select input is pulled low while master mode is on, the block leaves master mode, abandons any exchange, parks the clock at its idle level and sets the completion flag. It stays out of master mode until the master-enable strobe is given again. Both flags clear when software reads the status word while a flag is set and then reads or writes the data register.

Top module: `spi_byte_master`

## Requirements
- R1: While no transfer is running, `sck` equals `cfg_cpol` (low when 0, high when 1).
- R2: Data leaves MSB first on `mosi`. With `cfg_cpha`=0 the input is sampled on each leading `sck` edge and the next bit is driven after each trailing edge. With `cfg_cpha`=1 each leading edge drives a bit and each trailing edge samples.
- R3: One `sck` half-period lasts D/2 system clocks. D is 4, 16, 64 or 128 for `cfg_rate` 0..3 with `cfg_dbl`=0, and 2, 8, 32 or 64 with `cfg_dbl`=1. The first edge comes D/2 clocks after the clock edge that registers the start.
- R4: A transfer is exactly 8 `sck` periods (16 edges). It ends 16·D/2 clocks after its start, and `sck` is back at the idle level at that point.
- R5: `rx_byte` takes the 8 sampled `miso` bits, first sample in bit 7, in the cycle the transfer ends. It holds that value until the next completed transfer (reset value 0).
- R6: `status[7]` (done) is set in the cycle a transfer ends. The whole `status` word is 0 after reset, apart from bit 0, which follows `cfg_dbl`.
- R7: `status[6]` (collision) is set by a `data_wr` pulse during a transfer. That write changes neither the transmitted bits, the timing nor the received byte.
- R8: Done and collision both clear on the first `data_wr` or `data_rd` after a `stat_rd` that saw either flag set. A data access with no such prior status read clears nothing.
- R9: `ss_n` low while `master_on`=1 drops `master_on` to 0 on the next edge. It aborts a running transfer, returns `sck` to idle and sets `status[6+1]` (done). `master_on` returns to 1 only after a `mst_set` pulse.
- R10: While `master_on`=0, `data_wr` starts nothing and sets no flag. Changes to `cfg_rate` and `cfg_dbl` leave `sck` at its idle level.
- R11: `status[0]` reflects `cfg_dbl`, and `status[5:1]` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_rate | input | 2 | Rate code |
| cfg_dbl | input | 1 | Double-speed select, halves the divisor |
| mst_set | input | 1 | Pulse that turns master mode on |
| tx_byte | input | DATA_W | Byte to send, taken with `data_wr` |
| data_wr | input | 1 | Data register write strobe |
| data_rd | input | 1 | Data register read strobe |
| stat_rd | input | 1 | Status word read strobe |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low select input, low while master causes a mode fault |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| rx_byte | output | DATA_W | Last received byte |
| status | output | 8 | {done, collision, 5'b0, double-speed} |
| master_on | output | 1 | Master mode active |

## Verification
The bench builds the block with the default 8-bit word. It runs every combination of the four clock modes and the eight rate settings, from a single-cycle half-period (divisor 2) up to 64-cycle half-periods (divisor 128). This puts the edge-counter wrap and the divider wrap at both extremes within reach. A behavioural model predicts `sck`, `mosi`, `rx_byte`, `status` and `master_on` on every clock from timestamps alone. Directed cases then place a colliding write in mid-byte, run the two-step flag clear with and without the preceding status read, and raise a mode fault part-way through a byte.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

    // widest half-period count is 64 system clocks
    localparam int HALF_W = 7;

    typedef struct packed {
        logic       cpol;
        logic       cpha;
        logic       dbl;
        logic [1:0] rate;
    } spi_cfg_t;

    // number of system clocks in one serial half-period
    function automatic logic [HALF_W-1:0] half_period(input logic dbl, input logic [1:0] rate);
        logic [7:0] div;
        case (rate)
            2'd0:    div = 8'd4;
            2'd1:    div = 8'd16;
            2'd2:    div = 8'd64;
            default: div = 8'd128;
        endcase
        if (dbl) div = div >> 1;
        return HALF_W'(div >> 1);
    endfunction

endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_master_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       dbl,
    input  logic [1:0] rate,
    output logic       tick
);
    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] limit;

    assign limit = half_period(dbl, rate) - HALF_W'(1);
    assign tick  = run && (cnt == limit);

    // counter rests at zero whenever no byte is moving (R3)
    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + HALF_W'(1);
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic              cpha,
    input  logic [DATA_W-1:0] tx,
    input  logic              miso,
    output logic              busy,
    output logic              sck_raw,
    output logic              mosi,
    output logic              done_pulse,
    output logic [DATA_W-1:0] rx_data
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES + 1);

    logic [EW-1:0]     edge_cnt;
    logic [EW-1:0]     edge_no;
    logic              leading, sample, last, shift_ok;
    logic [DATA_W-1:0] shreg, rxsh, rx_next;

    assign edge_no    = edge_cnt + EW'(1);
    assign leading    = ~edge_cnt[0];
    assign sample     = leading ^ cpha;                        // R2
    assign last       = (edge_no == EW'(EDGES));               // R4
    assign shift_ok   = !sample && (edge_no != EW'(1)) && !last;
    assign rx_next    = sample ? {rxsh[DATA_W-2:0], miso} : rxsh;
    assign done_pulse = busy && tick && !abort && last;
    assign mosi       = shreg[DATA_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            sck_raw  <= 1'b0;
            edge_cnt <= '0;
            shreg    <= '0;
            rxsh     <= '0;
            rx_data  <= '0;
        end else if (abort) begin
            busy     <= 1'b0;
            sck_raw  <= 1'b0;
            edge_cnt <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            sck_raw  <= 1'b0;
            edge_cnt <= '0;
            shreg    <= tx;
        end else if (busy && tick) begin
            sck_raw  <= ~sck_raw;
            edge_cnt <= edge_no;
            if (sample)   rxsh  <= rx_next;
            if (shift_ok) shreg <= {shreg[DATA_W-2:0], 1'b0};
            if (last) begin
                busy    <= 1'b0;
                rx_data <= rx_next;                            // R5
            end
        end
    end
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
    input  logic clk,
    input  logic rst,
    input  logic set_done,
    input  logic set_wcol,
    input  logic stat_rd,
    input  logic data_acc,
    output logic done,
    output logic wcol
);
    logic armed;

    // clear first, then sets, so a same-cycle set wins (R8)
    always_ff @(posedge clk) begin
        if (rst) begin
            done  <= 1'b0;
            wcol  <= 1'b0;
            armed <= 1'b0;
        end else begin
            if (armed && data_acc) begin
                done  <= 1'b0;
                wcol  <= 1'b0;
                armed <= 1'b0;
            end
            if (stat_rd && (done || wcol)) armed <= 1'b1;
            if (set_done) done <= 1'b1;
            if (set_wcol) wcol <= 1'b1;
        end
    end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spi_master_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [1:0]        cfg_rate,
    input  logic              cfg_dbl,
    input  logic              mst_set,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic              stat_rd,
    input  logic              miso,
    input  logic              ss_n,
    output logic              sck,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte,
    output logic [7:0]        status,
    output logic              master_on
);
    spi_cfg_t cfg;
    logic     master_q, fault, start, wcol_set;
    logic     tick, xfer_busy, sck_raw, done_pulse;
    logic     done_f, wcol_f;

    assign cfg      = '{cpol: cfg_cpol, cpha: cfg_cpha, dbl: cfg_dbl, rate: cfg_rate};
    assign fault    = master_q && !ss_n;                              // R9
    assign start    = data_wr && master_q && !xfer_busy && ss_n;      // R10
    assign wcol_set = data_wr && xfer_busy;                           // R7

    always_ff @(posedge clk) begin
        if (rst)          master_q <= 1'b0;
        else if (fault)   master_q <= 1'b0;
        else if (mst_set) master_q <= 1'b1;
    end

    spi_rate_gen u_rate (
        .clk  (clk),
        .rst  (rst),
        .run  (xfer_busy),
        .dbl  (cfg.dbl),
        .rate (cfg.rate),
        .tick (tick)
    );

    spi_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .abort      (fault),
        .tick       (tick),
        .cpha       (cfg.cpha),
        .tx         (tx_byte),
        .miso       (miso),
        .busy       (xfer_busy),
        .sck_raw    (sck_raw),
        .mosi       (mosi),
        .done_pulse (done_pulse),
        .rx_data    (rx_byte)
    );

    spi_flag_unit u_flags (
        .clk      (clk),
        .rst      (rst),
        .set_done (done_pulse || fault),
        .set_wcol (wcol_set),
        .stat_rd  (stat_rd),
        .data_acc (data_wr || data_rd),
        .done     (done_f),
        .wcol     (wcol_f)
    );

    assign sck       = sck_raw ^ cfg.cpol;                            // R1
    assign status    = {done_f, wcol_f, 5'b0, cfg.dbl};               // R6 R11
    assign master_on = master_q;
endmodule

// File: rtl/spi_master_checker.sv
module spi_master_checker (
    input logic       clk,
    input logic       rst,
    input logic       sck,
    input logic       cpol,
    input logic       busy,
    input logic       mosi,
    input logic       data_wr,
    input logic       ss_n,
    input logic       master,
    input logic [7:0] status
);
    assert_idle_level_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck == cpol));

    assert_mosi_holds_R2: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && $stable(sck)) |-> $stable(mosi));

    assert_done_on_stop_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> status[7]);

    assert_collision_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && data_wr) |=> status[6]);

    assert_fault_exit_R9: assert property (@(posedge clk) disable iff (rst)
        (master && !ss_n) |=> (!master && status[7] && !busy));

    assert_idle_without_master_R10: assert property (@(posedge clk) disable iff (rst)
        !master |=> !busy);
endmodule

bind spi_byte_master spi_master_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .sck     (sck),
    .cpol    (cfg_cpol),
    .busy    (xfer_busy),
    .mosi    (mosi),
    .data_wr (data_wr),
    .ss_n    (ss_n),
    .master  (master_on),
    .status  (status)
);

// File: tb/spi_byte_master_test.sv
module spi_byte_master_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_dbl = 1'b0;
    logic [1:0]    cfg_rate = 2'd0;
    logic          mst_set = 1'b0, data_wr = 1'b0, data_rd = 1'b0, stat_rd = 1'b0;
    logic [DW-1:0] tx_byte = '0;
    logic          miso = 1'b1, ss_n = 1'b1;
    logic          sck, mosi, master_on;
    logic [DW-1:0] rx_byte;
    logic [7:0]    status;

    int n_vec = 0;
    int n_bad = 0;
    int cyc = 0;

    // model state
    bit            m_master = 0, m_busy = 0, m_done = 0, m_wcol = 0, m_arm = 0;
    int            m_t0 = 0, m_half = 1, m_cpha = 0;
    logic [7:0]    m_tx = '0, m_rx = '0, m_slave = '0;
    logic [7:0]    slave_next = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_byte_master #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_rate(cfg_rate), .cfg_dbl(cfg_dbl), .mst_set(mst_set),
        .tx_byte(tx_byte), .data_wr(data_wr), .data_rd(data_rd),
        .stat_rd(stat_rd), .miso(miso), .ss_n(ss_n), .sck(sck),
        .mosi(mosi), .rx_byte(rx_byte), .status(status), .master_on(master_on)
    );

    function automatic int exp_half(input bit dbl, input int rate);
        int d;
        d = (rate == 3) ? 128 : (4 << (2 * rate));
        if (dbl) d = d / 2;
        return d / 2;
    endfunction

    // which bit of the byte is on the wire after e clock edges
    function automatic int bit_idx(input int e, input int pha);
        if (pha == 0) return e / 2;
        if (e == 0) return 0;
        return (e + 1) / 2 - 1;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // reference model, evaluated just after every rising edge
    always @(posedge clk) begin
        bit fault, complete, busy_prev, master_prev, old_d, old_w, old_arm;
        int e;
        #2;
        cyc++;
        if (rst) begin
            m_master = 0; m_busy = 0; m_done = 0; m_wcol = 0; m_arm = 0;
            m_rx = '0;
        end else begin
            busy_prev   = m_busy;
            master_prev = m_master;
            old_d = m_done; old_w = m_wcol; old_arm = m_arm;
            fault    = master_prev && !ss_n;
            complete = busy_prev && ((cyc - m_t0) == 2 * DW * m_half);
            if (old_arm && (data_wr || data_rd)) begin
                m_done = 0; m_wcol = 0; m_arm = 0;
            end
            if (stat_rd && (old_d || old_w)) m_arm = 1;
            if (fault) begin
                m_busy = 0; m_done = 1;
            end else if (complete) begin
                m_busy = 0; m_done = 1; m_rx = m_slave;
            end
            if (data_wr && busy_prev) m_wcol = 1;
            if (data_wr && master_prev && !busy_prev && ss_n) begin
                m_busy = 1; m_t0 = cyc; m_tx = tx_byte; m_slave = slave_next;
                m_half = exp_half(cfg_dbl, int'(cfg_rate)); m_cpha = int'(cfg_cpha);
            end
            if (fault)        m_master = 0;
            else if (mst_set) m_master = 1;
        end
        e = m_busy ? (cyc - m_t0) / m_half : 0;
        if (m_busy) begin
            chk("R3", "sck during transfer", 32'(sck), 32'(cfg_cpol ^ e[0]));
            chk("R2", "mosi bit", 32'(mosi), 32'(m_tx[7 - bit_idx(e, m_cpha)]));
        end else begin
            chk("R1", "sck idle", 32'(sck), 32'(cfg_cpol));
        end
        chk("R5", "rx_byte", 32'(rx_byte), 32'(m_rx));
        chk("R6", "done flag", 32'(status[7]), 32'(m_done));
        chk("R7", "collision flag", 32'(status[6]), 32'(m_wcol));
        chk("R11", "status low bits", 32'(status[5:0]), 32'({5'b0, cfg_dbl}));
        chk("R9", "master_on", 32'(master_on), 32'(m_master));
        miso = m_busy ? m_slave[7 - bit_idx(e, m_cpha)] : 1'b1;
    end

    task automatic pulse_wr(input logic [7:0] d);
        @(negedge clk); tx_byte = d; data_wr = 1'b1;
        @(negedge clk); data_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); data_rd = 1'b1;
        @(negedge clk); data_rd = 1'b0;
    endtask

    task automatic pulse_stat();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic pulse_mst();
        @(negedge clk); mst_set = 1'b1;
        @(negedge clk); mst_set = 1'b0;
    endtask

    task automatic clear_flags();
        pulse_stat();
        pulse_rd();
    endtask

    task automatic run_xfer(input bit pol, input bit pha, input bit dbl, input int rate,
                            input logic [7:0] txv, input logic [7:0] slv);
        int h;
        h = exp_half(dbl, rate);
        @(negedge clk);
        cfg_cpol = pol; cfg_cpha = pha; cfg_dbl = dbl; cfg_rate = 2'(rate); slave_next = slv;
        @(negedge clk);
        chk("R1", "idle level before start", 32'(sck), 32'(pol));
        pulse_wr(txv);
        repeat (2 * DW * h - 1) @(negedge clk);
        chk("R4", "done one clock before last edge", 32'(status[7]), 32'(0));
        @(negedge clk);
        chk("R4", "done after sixteen edges", 32'(status[7]), 32'(1));
        chk("R4", "sck back at idle", 32'(sck), 32'(pol));
        chk("R5", "received byte", 32'(rx_byte), 32'(slv));
        clear_flags();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL R4 watchdog: got timeout expected end of sequence");
        finish_run();
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R6", "status after reset", 32'(status), 32'(0));
        chk("R9", "master off after reset", 32'(master_on), 32'(0));

        // R10: writes and rate changes with master mode off
        slave_next = 8'h00;
        pulse_wr(8'hFF);
        cfg_rate = 2'd3; cfg_dbl = 1'b1;
        repeat (12) begin
            @(negedge clk);
            chk("R10", "sck stays idle without master", 32'(sck), 32'(cfg_cpol));
        end
        chk("R10", "no flags without master", 32'(status[7:6]), 32'(0));
        chk("R11", "double-speed bit reflected", 32'(status[0]), 32'(1));
        cfg_dbl = 1'b0;

        pulse_mst();
        chk("R9", "master set", 32'(master_on), 32'(1));

        // all modes at all rates (R2 R3 R4 R5)
        k = 0;
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int r = 0; r < 4; r++) begin
                    run_xfer(m[1], m[0], d[0], r, 8'(8'hA5 ^ (k * 37)), 8'(8'h3C + k * 53));
                    k++;
                end
            end
        end

        // R7: collision in mid-byte
        @(negedge clk); cfg_cpol = 1'b0; cfg_cpha = 1'b1; cfg_dbl = 1'b0; cfg_rate = 2'd1;
        slave_next = 8'h5A;
        pulse_wr(8'h96);
        repeat (20) @(negedge clk);
        pulse_wr(8'h11);
        chk("R7", "collision flag raised", 32'(status[6]), 32'(1));
        chk("R7", "done not yet", 32'(status[7]), 32'(0));
        repeat (130) @(negedge clk);
        chk("R7", "byte after collision", 32'(rx_byte), 32'(8'h5A));
        chk("R7", "done after collision", 32'(status[7]), 32'(1));

        // R8: clear sequence
        pulse_rd();
        chk("R8", "data read without status read keeps flags", 32'(status[7:6]), 32'(2'b11));
        pulse_stat();
        chk("R8", "status read alone keeps flags", 32'(status[7:6]), 32'(2'b11));
        pulse_rd();
        chk("R8", "flags cleared", 32'(status[7:6]), 32'(0));

        // R9: mode fault in mid-byte
        @(negedge clk); cfg_cpol = 1'b1; cfg_cpha = 1'b0; cfg_rate = 2'd0;
        slave_next = 8'hC3;
        pulse_wr(8'h3C);
        repeat (5) @(negedge clk);
        ss_n = 1'b0;
        @(negedge clk);
        ss_n = 1'b1;
        chk("R9", "master dropped", 32'(master_on), 32'(0));
        chk("R9", "done set by fault", 32'(status[7]), 32'(1));
        chk("R9", "sck parked", 32'(sck), 32'(1));
        clear_flags();
        pulse_wr(8'h77);
        repeat (10) @(negedge clk);
        chk("R9", "stays out of master mode", 32'(master_on), 32'(0));
        chk("R10", "write ignored after fault", 32'(status[7:6]), 32'(0));
        chk("R10", "sck idle after fault", 32'(sck), 32'(1));
        pulse_mst();
        chk("R9", "master restored", 32'(master_on), 32'(1));
        run_xfer(1'b0, 1'b0, 1'b1, 0, 8'h81, 8'h7E);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule